// File: doc/BRIEF.md
# Two-Dimensional Burst Address Generator

This block turns one transfer descriptor into the ordered list of burst requests that a memory-mapped master port has to issue. A descriptor gives a base address, the row size in bytes minus one, the row count minus one, a row stride and a cyclic flag. The block walks the rows one after another. It cuts each row into bursts of a fixed power-of-two byte size, and the remainder of the row forms a final, shorter burst. Each request carries an aligned byte address and a beat count minus one, and a flag marks the burst that closes the transfer.

A request is presented with a valid/ready handshake and is held until it is accepted. In cyclic mode the same walk starts again at once after the closing burst and goes on until the enable input is cleared. When enable is dropped, a request that is already on the port still completes, and no further request follows. The data path, buffering and software registers belong to neighbouring blocks.

Top module: `dma2d_burst_gen`

## Requirements
- R1: After reset, busy, req_valid and done are low, and desc_ready equals enable.
- R2: A descriptor is taken only when enable is high and busy is low (desc_ready = enable and not busy). busy rises the cycle after acceptance and stays high until the closing burst has been accepted. While busy is high, no descriptor is taken and req_valid is low only when no request is pending.
- R3: The base address and the stride are aligned by forcing their low log2(DATA_BYTES) bits to zero. Row N starts at aligned base + N * aligned stride.
- R4: A row of desc_xlen+1 bytes is issued as full bursts of BURST_BYTES each, followed by one burst holding the remainder. Successive bursts in a row are BURST_BYTES apart. For a burst of b bytes, req_beats_m1 = ceil(b / DATA_BYTES) - 1.
- R5: BURST_BYTES equals the smaller of MAX_BURST_BYTES and (16 if AXI3 = 1, else 256) times DATA_BYTES.
- R6: A transfer covers desc_ylen+1 rows. With ENABLE_2D = 0, desc_ylen is ignored and exactly one row is issued.
- R7: req_last is high on the final burst of the final row and low on every other burst.
- R8: While req_valid is high and req_ready is low, req_valid, req_addr, req_beats_m1 and req_last hold their values into the next cycle.
- R9: In non-cyclic mode, done pulses high for exactly one cycle, in the cycle after the closing burst is accepted, and busy is low in that same cycle.
- R10: In cyclic mode, the closing burst is followed by the same burst sequence again from row 0, with no done pulse, for as long as enable stays high.
- R11: When enable is low, no new request is raised. A request already presented stays up until it is accepted. After that acceptance, or at once if no request is pending, busy drops and no done pulse is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low stops at a burst boundary |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_addr | input | ADDR_W | Base byte address |
| desc_xlen | input | LEN_W | Bytes per row minus one |
| desc_ylen | input | LEN_W | Rows minus one |
| desc_stride | input | ADDR_W | Byte distance between row starts |
| desc_cyclic | input | 1 | Restart automatically after the closing burst |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | ADDR_W | Aligned burst start address |
| req_beats_m1 | output | 8 | Beats in the burst minus one |
| req_last | output | 1 | Closing burst of the transfer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse (non-cyclic) |

## Verification
The properties assume that the consumer of the request port follows a plain valid/ready protocol, and that enable changes only between clock edges. They also assume that a descriptor is offered only while desc_ready is high. The bench drives every input at the falling edge and holds desc_valid for exactly one accepting edge. It toggles req_ready randomly, with a fixed seed, so that held requests are exercised. Row sizes are kept below about 700 bytes and row counts below six, so the expected burst list stays small enough to build in full. The list is compared entry by entry against the handshakes observed on the port.

// File: rtl/dma2d_burst_gen.sv
module dma2d_burst_gen #(
  parameter int ADDR_W          = 32,
  parameter int LEN_W           = 24,
  parameter int DATA_BYTES      = 8,
  parameter int MAX_BURST_BYTES = 128,
  parameter bit ENABLE_2D       = 1'b1,
  parameter bit AXI3            = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_xlen,
  input  logic [LEN_W-1:0]  desc_ylen,
  input  logic [ADDR_W-1:0] desc_stride,
  input  logic              desc_cyclic,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_beats_m1,
  output logic              req_last,
  output logic              busy,
  output logic              done
);
  localparam int ALIGN_W     = $clog2(DATA_BYTES);
  localparam int PROTO_BEATS = AXI3 ? 16 : 256;
  localparam int BURST_BYTES = (MAX_BURST_BYTES < PROTO_BEATS * DATA_BYTES) ?
                               MAX_BURST_BYTES : PROTO_BEATS * DATA_BYTES;
  localparam int REM_W       = LEN_W + 1;
  localparam logic [ADDR_W-1:0] AMASK   = {ADDR_W{1'b1}} << ALIGN_W;
  localparam logic [REM_W-1:0]  BURST_R = REM_W'(BURST_BYTES);
  localparam logic [ADDR_W-1:0] BURST_A = ADDR_W'(BURST_BYTES);

  logic              active, vld, done_q, cyclic_q;
  logic [ADDR_W-1:0] base_q, stride_q, row_addr, cur_addr;
  logic [LEN_W-1:0]  xlen_q, ylen_q, rows_left;
  logic [REM_W-1:0]  rem;

  logic              full, xfer_end, hs, accept;
  logic [REM_W-1:0]  this_bytes, row_bytes;
  logic [LEN_W-1:0]  ylen_in;

  assign ylen_in    = ENABLE_2D ? desc_ylen : '0;
  assign full       = rem > BURST_R;
  assign this_bytes = full ? BURST_R : rem;
  assign row_bytes  = {1'b0, xlen_q} + REM_W'(1);
  assign xfer_end   = !full && (rows_left == '0);
  assign hs         = vld && req_ready;
  assign accept     = desc_valid && desc_ready;

  assign desc_ready   = enable && !active;
  assign busy         = active;
  assign done         = done_q;
  assign req_valid    = vld;
  assign req_addr     = cur_addr;
  assign req_beats_m1 = 8'((this_bytes - REM_W'(1)) >> ALIGN_W);
  assign req_last     = xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      vld       <= 1'b0;
      done_q    <= 1'b0;
      cyclic_q  <= 1'b0;
      base_q    <= '0;
      stride_q  <= '0;
      row_addr  <= '0;
      cur_addr  <= '0;
      xlen_q    <= '0;
      ylen_q    <= '0;
      rows_left <= '0;
      rem       <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        base_q    <= desc_addr & AMASK;
        stride_q  <= desc_stride & AMASK;
        row_addr  <= desc_addr & AMASK;
        cur_addr  <= desc_addr & AMASK;
        xlen_q    <= desc_xlen;
        ylen_q    <= ylen_in;
        rows_left <= ylen_in;
        rem       <= {1'b0, desc_xlen} + REM_W'(1);
        cyclic_q  <= desc_cyclic;
        active    <= 1'b1;
      end else if (active) begin
        if (hs) begin
          if (full) begin
            rem      <= rem - BURST_R;
            cur_addr <= cur_addr + BURST_A;
          end else if (rows_left != '0) begin
            rows_left <= rows_left - LEN_W'(1);
            row_addr  <= row_addr + stride_q;
            cur_addr  <= row_addr + stride_q;
            rem       <= row_bytes;
          end else begin
            rows_left <= ylen_q;
            row_addr  <= base_q;
            cur_addr  <= base_q;
            rem       <= row_bytes;
          end
          if (!enable || (xfer_end && !cyclic_q)) begin
            vld    <= 1'b0;
            active <= 1'b0;
            done_q <= xfer_end && !cyclic_q;
          end
        end else if (!vld) begin
          if (enable) vld <= 1'b1;
          else active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma2d_burst_gen_chk.sv
module dma2d_burst_gen_chk #(
  parameter int ADDR_W          = 32,
  parameter int DATA_BYTES      = 8,
  parameter int MAX_BURST_BYTES = 128,
  parameter bit AXI3            = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_beats_m1,
  input logic              req_last,
  input logic              busy,
  input logic              done
);
  localparam int PROTO_BEATS = AXI3 ? 16 : 256;
  localparam int BURST_BYTES = (MAX_BURST_BYTES < PROTO_BEATS * DATA_BYTES) ?
                               MAX_BURST_BYTES : PROTO_BEATS * DATA_BYTES;
  localparam int BEATS_MAX   = (BURST_BYTES + DATA_BYTES - 1) / DATA_BYTES;
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'(DATA_BYTES - 1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> busy); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & LOW) == '0); // R3
  AST_BEATS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> int'(req_beats_m1) < BEATS_MAX); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
    $stable(req_beats_m1) && $stable(req_last)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !req_valid |=> !req_valid); // R11
  AST_STOP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && req_valid && req_ready |=> !req_valid && !busy); // R11
endmodule

bind dma2d_burst_gen dma2d_burst_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
  .MAX_BURST_BYTES(MAX_BURST_BYTES), .AXI3(AXI3)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(desc_valid),
  .desc_ready(desc_ready), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_beats_m1(req_beats_m1), .req_last(req_last),
  .busy(busy), .done(done)
);

// File: tb/dma2d_burst_gen_tb.sv
`timescale 1ns/1ps
module dma2d_burst_gen_tb_top;
  localparam int DB = 8;
  localparam int BURST = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, desc_valid = 1'b0, desc_cyclic = 1'b0, req_ready = 1'b0;
  logic desc_ready, req_valid, req_last, busy, done;
  logic [31:0] desc_addr = '0, desc_stride = '0, req_addr;
  logic [23:0] desc_xlen = '0, desc_ylen = '0;
  logic [7:0]  req_beats_m1;

  logic b_enable = 1'b0, b_desc_valid = 1'b0;
  logic b_desc_ready, b_req_valid, b_req_last, b_busy, b_done;
  logic [31:0] b_req_addr;
  logic [7:0]  b_req_beats_m1;

  int total = 0, fails = 0;
  logic [31:0] e_addr [0:2047];
  int          e_beats[0:2047];
  bit          e_last [0:2047];
  int          e_n;
  int          got;

  always #4 clk = ~clk;

  dma2d_burst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_xlen(desc_xlen),
    .desc_ylen(desc_ylen), .desc_stride(desc_stride), .desc_cyclic(desc_cyclic),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats_m1(req_beats_m1), .req_last(req_last), .busy(busy), .done(done)
  );

  dma2d_burst_gen #(.MAX_BURST_BYTES(512), .ENABLE_2D(1'b0), .AXI3(1'b1)) dut1d_i (
    .clk(clk), .rst_n(rst_n), .enable(b_enable), .desc_valid(b_desc_valid),
    .desc_ready(b_desc_ready), .desc_addr(32'h0000_1003), .desc_xlen(24'd299),
    .desc_ylen(24'd4), .desc_stride(32'h100), .desc_cyclic(1'b0),
    .req_valid(b_req_valid), .req_ready(1'b1), .req_addr(b_req_addr),
    .req_beats_m1(b_req_beats_m1), .req_last(b_req_last), .busy(b_busy), .done(b_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] base, input int xlen, input int ylen,
                       input logic [31:0] stride, input int burst, input bit en2d);
    logic [31:0] a0, st, ra;
    int rows, left, off, b;
    a0 = base & ~32'(DB - 1);
    st = stride & ~32'(DB - 1);
    rows = en2d ? ylen + 1 : 1;
    e_n = 0;
    for (int r = 0; r < rows; r++) begin
      ra = a0 + st * 32'(r);
      left = xlen + 1;
      off = 0;
      while (left > 0) begin
        b = (left > burst) ? burst : left;
        e_addr[e_n]  = ra + 32'(off);
        e_beats[e_n] = (b + DB - 1) / DB - 1;
        e_last[e_n]  = (r == rows - 1) && (left <= burst);
        e_n++;
        left -= b;
        off  += burst;
      end
    end
  endtask

  task automatic submit(input logic [31:0] base, input int xlen, input int ylen,
                        input logic [31:0] stride, input bit cyc);
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    while (!desc_ready) begin @(negedge clk); #1; end
    desc_addr = base; desc_xlen = 24'(xlen); desc_ylen = 24'(ylen);
    desc_stride = stride; desc_cyclic = cyc; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    #1;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    chk(desc_ready == 1'b0, "R2", "desc_ready while busy", desc_ready, 0);
    build(base, xlen, ylen, stride, BURST, 1'b1);
    got = 0;
  endtask

  task automatic run(input int limit, input int pct);
    int early = 0, guard = 0, k;
    while (got < limit && guard < 20000) begin
      @(negedge clk);
      req_ready = ($urandom % 100) < pct;
      #1;
      guard++;
      if (done) early++;
      if (req_valid && req_ready) begin
        k = got % e_n;
        chk(req_addr == e_addr[k], "R3", "burst address", req_addr, e_addr[k]);
        chk(int'(req_beats_m1) == e_beats[k], "R4", "beats minus one", req_beats_m1, e_beats[k]);
        chk(req_last == e_last[k], "R7", "last flag", req_last, e_last[k]);
        got++;
      end
    end
    chk(early == 0, "R10", "no done during walk", early, 0);
  endtask

  task automatic finish_check();
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    chk(done == 1'b1, "R9", "done pulse", done, 1);
    chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
  endtask

  task automatic stop_drain(input string req);
    int nh = 0, dn = 0, pend;
    @(negedge clk);
    req_ready = 1'b0;
    enable = 1'b0;
    #1;
    pend = req_valid;
    repeat (10) begin
      @(negedge clk);
      req_ready = 1'b1;
      #1;
      if (done) dn++;
      if (req_valid && req_ready) begin
        if (nh == 0)
          chk(req_addr == e_addr[got % e_n], req, "pending burst", req_addr, e_addr[got % e_n]);
        nh++;
        got++;
      end
    end
    req_ready = 1'b0;
    chk(nh == pend, "R11", "handshakes after disable", nh, pend);
    chk(dn == 0, "R11", "no done on stop", dn, 0);
    chk(busy == 1'b0, "R11", "busy low after stop", busy, 0);
    enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n1;
    void'($urandom(32'h5eed_2d01));
    enable = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(req_valid == 0, "R1", "req_valid after reset", req_valid, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(desc_ready == 1, "R1", "desc_ready after reset", desc_ready, 1);

    submit(32'h0000_2000, BURST - 1, 0, 32'h0, 1'b0); run(e_n, 100); finish_check();
    submit(32'h0000_3005, BURST, 1, 32'h0000_0403, 1'b0); run(e_n, 50); finish_check();
    submit(32'hffff_fff8, 0, 2, 32'h10, 1'b0); run(e_n, 70); finish_check();
    submit(32'h0000_4000, 7, 3, 32'h40, 1'b0);
    chk(e_n == 4, "R6", "row count", e_n, 4);
    run(e_n, 80); finish_check();

    for (int i = 0; i < 12; i++) begin
      submit($urandom, int'($urandom % 700), int'($urandom % 5), $urandom % 2048, 1'b0);
      run(e_n, 40 + int'($urandom % 60));
      finish_check();
    end

    submit(32'h0001_0000, 300, 2, 32'h200, 1'b1);
    run(2 * e_n + 2, 60);
    stop_drain("R10");

    submit(32'h0002_0000, 1000, 3, 32'h800, 1'b0);
    run(3, 50);
    stop_drain("R11");

    @(negedge clk);
    b_enable = 1'b1;
    b_desc_valid = 1'b1;
    @(negedge clk);
    b_desc_valid = 1'b0;
    build(32'h0000_1003, 299, 4, 32'h100, 128, 1'b0);
    n1 = 0;
    repeat (30) begin
      @(negedge clk);
      #1;
      if (b_req_valid) begin
        if (n1 < e_n) begin
          chk(b_req_addr == e_addr[n1], "R5", "capped burst address", b_req_addr, e_addr[n1]);
          chk(int'(b_req_beats_m1) == e_beats[n1], "R5", "capped beats", b_req_beats_m1, e_beats[n1]);
        end
        n1++;
      end
    end
    chk(n1 == e_n, "R6", "single row when 2D off", n1, e_n);
    chk(b_busy == 0, "R6", "1D instance idle", b_busy, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule